// File: doc/BRIEF.md
# Descriptor Fetch Sequencer

This block prepares one DMA channel for a transfer. It holds the channel working registers: next pointer, start address, configuration, X/Y counts and X/Y strides, and a current-descriptor pointer. Software or a host preloads them through a small write port while the block is idle. When `start_i` is pulsed, the sequencer decodes the flow mode and descriptor size from the configuration register. It then reads the needed 16-bit descriptor words over a request/valid memory port and stores them into the working registers. The words always follow one fixed slot order, but each flow mode enters that order at its own slot.

When the words are stored, the sequencer sets the current descriptor pointer, current address and current X/Y counts, and checks the start address against the element size. It then gives a one-cycle done pulse. A flow mode and descriptor size that do not fit together are rejected with a configuration error flag, and no memory traffic follows. The data mover that later uses the current registers is a separate block.

Top module: `desc_fetch_seq`

## Requirements
- R1: After reset every working and current register is zero, and `busy_o`, `done_o`, `rd_req_o`, `cfg_err_o` and `align_err_o` are low.
- R2: While idle, `wr_en_i` writes `wr_data_i` into the slot chosen by `wr_sel_i`: 0 next-lo, 1 next-hi, 2 start-lo, 3 start-hi, 4 config, 5 X count, 6 X stride, 7 Y count, 8 Y stride, 9 current-pointer lo, 10 current-pointer hi. A write while busy has no effect.
- R3: Config bits [2:0] select the flow: 0 stop, 1 autobuffer, 2 array, 3 small list, 4 large list. Bits [7:4] give the descriptor size in words. Codes 5 to 7, or a size outside the range allowed for the flow, set `cfg_err_o`, issue no read, leave the block idle and leave the registers unchanged.
- R4: Stop and autobuffer need size 0. They fetch nothing and go straight to setting up the current registers.
- R5: Large-list mode needs size 1 to 9. It reads that many words from the next pointer at byte addresses rising by 2, and stores them from slot 0 upward.
- R6: Small-list mode needs size 1 to 8. It reads from the next pointer and stores from slot 1 (next-hi) upward, so next-lo keeps its value.
- R7: Array mode needs size 1 to 7. It reads from the current-descriptor pointer and stores from slot 2 (start-lo) upward.
- R8: After loading, the current descriptor pointer equals the next pointer, and the current address equals the start address {slot 3, slot 2}.
- R9: A stored X or Y count of zero loads the current count as 0xFFFF. Any other count loads unchanged.
- R10: Config bits [9:8] give the element size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. This uses the configuration value after loading. A start address that is not a multiple of the element size sets `align_err_o`. A correctly aligned address clears it. An accepted start also clears it.
- R11: `done_o` pulses high for one cycle, two cycles after the cycle in which the last word's `rd_valid_i` is high. `busy_o` is low while `done_o` is high.
- R12: At most one read is outstanding. `rd_req_o` is a one-cycle pulse and `rd_addr_o` holds until the reply. A `start_i` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Preload write strobe |
| wr_sel_i | input | 4 | Preload slot select |
| wr_data_i | input | DW | Preload data |
| start_i | input | 1 | Start/continue request |
| rd_req_o | output | 1 | Memory read request pulse |
| rd_addr_o | output | 2*DW | Byte address of the descriptor word |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | DW | Read data word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_err_o | output | 1 | Last start rejected |
| align_err_o | output | 1 | Start address misaligned |
| cfg_o | output | DW | Configuration register |
| next_ptr_o | output | 2*DW | Next descriptor pointer |
| start_addr_o | output | 2*DW | Start address |
| xcnt_o | output | DW | X count register |
| xmod_o | output | DW | X stride register |
| ycnt_o | output | DW | Y count register |
| ymod_o | output | DW | Y stride register |
| cur_desc_o | output | 2*DW | Current descriptor pointer |
| cur_addr_o | output | 2*DW | Current address |
| cur_x_o | output | DW | Current X count |
| cur_y_o | output | DW | Current Y count |

## Verification
The bench builds the block with the default word width of 16. This gives 32-bit pointers built from two slots and a 4-bit size field. That field can encode sizes of 10 and above, so the over-range rejection in every list mode can be tested. The bench memory's reply latency is a bench variable, set between 0 and 3 cycles. The higher latencies keep the sequencer busy long enough to test writes and starts that arrive mid-fetch.

// File: rtl/dfs_pkg.sv
// Package: shared constants and types of the descriptor fetch sequencer.
// Assumes the configuration word is at least 10 bits wide.
package dfs_pkg;
    localparam int NUM_SLOTS = 9;
    localparam int SEL_W     = 4;
    localparam int NDS_W     = 4;
    localparam int FLOW_LSB  = 0;
    localparam int FLOW_W    = 3;
    localparam int NDS_LSB   = 4;
    localparam int WSZ_LSB   = 8;
    localparam int WSZ_W     = 2;

    // Slot codes; the fetch order depends on these positions.
    localparam logic [SEL_W-1:0] SL_NXT_LO = 4'd0;
    localparam logic [SEL_W-1:0] SL_NXT_HI = 4'd1;
    localparam logic [SEL_W-1:0] SL_STA_LO = 4'd2;
    localparam logic [SEL_W-1:0] SL_STA_HI = 4'd3;
    localparam logic [SEL_W-1:0] SL_CFG    = 4'd4;
    localparam logic [SEL_W-1:0] SL_XCNT   = 4'd5;
    localparam logic [SEL_W-1:0] SL_XMOD   = 4'd6;
    localparam logic [SEL_W-1:0] SL_YCNT   = 4'd7;
    localparam logic [SEL_W-1:0] SL_YMOD   = 4'd8;
    localparam logic [SEL_W-1:0] SL_CUR_LO = 4'd9;
    localparam logic [SEL_W-1:0] SL_CUR_HI = 4'd10;

    typedef enum logic [FLOW_W-1:0] {
        FL_STOP  = 3'd0,
        FL_AUTO  = 3'd1,
        FL_ARRAY = 3'd2,
        FL_SMALL = 3'd3,
        FL_LARGE = 3'd4
    } flow_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_FIN
    } seq_state_e;

    // True when the low address bits break the element-size alignment.
    function automatic logic misaligned(input logic [WSZ_W-1:0] wsz,
                                        input logic [1:0] lsb);
        if (wsz == 2'd0)      return 1'b0;
        else if (wsz == 2'd1) return lsb[0];
        else                  return lsb != 2'd0;
    endfunction
endpackage

// File: rtl/dfs_mode_dec.sv
// Module: decodes the flow mode and descriptor size from a configuration word.
// Works out legality, the first slot to load, and where the pointer comes from.
// Assumes list modes may load every slot from their entry slot to the end.
module dfs_mode_dec
    import dfs_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0]    cfg_i,
    output logic             legal_o,
    output logic             no_fetch_o,
    output logic             from_cur_o,
    output logic [SEL_W-1:0] first_o,
    output logic [NDS_W-1:0] nwords_o
);
    flow_e            flow;
    logic [NDS_W-1:0] nds;
    logic [NDS_W-1:0] span;
    logic             list_mode;

    assign flow     = flow_e'(cfg_i[FLOW_LSB +: FLOW_W]);
    assign nds      = cfg_i[NDS_LSB +: NDS_W];
    assign nwords_o = nds;
    assign span     = NDS_W'(NUM_SLOTS) - NDS_W'(first_o);

    // Pick the entry slot and pointer source for each flow.
    always_comb begin
        first_o    = SL_NXT_LO;
        from_cur_o = 1'b0;
        no_fetch_o = 1'b0;
        list_mode  = 1'b0;
        case (flow)
            FL_STOP, FL_AUTO: no_fetch_o = 1'b1;
            FL_ARRAY: begin
                first_o    = SL_STA_LO;
                from_cur_o = 1'b1;
                list_mode  = 1'b1;
            end
            FL_SMALL: begin
                first_o   = SL_NXT_HI;
                list_mode = 1'b1;
            end
            FL_LARGE: list_mode = 1'b1;
            default:  list_mode = 1'b0;
        endcase
    end

    // Range check: zero for fetch-free flows, 1..span for list flows.
    always_comb begin
        if (no_fetch_o)     legal_o = (nds == '0);
        else if (list_mode) legal_o = (nds != '0) && (nds <= span);
        else                legal_o = 1'b0;
    end
endmodule

// File: rtl/dfs_slot_regs.sv
// Module: the channel working registers and the current-state registers.
// Slots take writes by index. An init strobe copies the pointer, address
// and counts into the current set. Assumes only one writer per cycle.
module dfs_slot_regs
    import dfs_pkg::*;
#(
    parameter int DW = 16,
    localparam int AW = 2 * DW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic [DW-1:0]                 wdata_i,
    input  logic                          init_i,
    output logic [NUM_SLOTS-1:0][DW-1:0]  slot_o,
    output logic [AW-1:0]                 cur_ptr_o,
    output logic [AW-1:0]                 cur_addr_o,
    output logic [DW-1:0]                 cur_x_o,
    output logic [DW-1:0]                 cur_y_o
);
    localparam logic [DW-1:0] CNT_FULL = {DW{1'b1}};

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [DW-1:0] q;
        // Hold one descriptor slot; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                                q <= '0;
            else if (we_i && sel_i == SEL_W'(i))       q <= wdata_i;
        end
        assign slot_o[i] = q;
    end

    // Current descriptor pointer: follows next pointer on init, else preloadable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cur_ptr_o <= '0;
        else if (init_i)                             cur_ptr_o <= {slot_o[SL_NXT_HI], slot_o[SL_NXT_LO]};
        else if (we_i && sel_i == SL_CUR_LO)         cur_ptr_o[DW-1:0] <= wdata_i;
        else if (we_i && sel_i == SL_CUR_HI)         cur_ptr_o[AW-1:DW] <= wdata_i;
    end

    // Current address and counts: set up on init, zero counts mean full range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_o <= '0;
            cur_x_o    <= '0;
            cur_y_o    <= '0;
        end else if (init_i) begin
            cur_addr_o <= {slot_o[SL_STA_HI], slot_o[SL_STA_LO]};
            cur_x_o    <= (slot_o[SL_XCNT] == '0) ? CNT_FULL : slot_o[SL_XCNT];
            cur_y_o    <= (slot_o[SL_YCNT] == '0) ? CNT_FULL : slot_o[SL_YCNT];
        end
    end

    p_count_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (cur_x_o != '0 && cur_y_o != '0));
endmodule

// File: rtl/dfs_fetch_ctl.sv
// Module: sequencer state machine. It accepts a start, issues one read at
// a time, and steers each returned word to the next slot. It then strobes
// init and reports done and errors. Assumes each request gets exactly one
// rd_valid, no earlier than the cycle after the request.
module dfs_fetch_ctl
    import dfs_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             legal_i,
    input  logic             no_fetch_i,
    input  logic [SEL_W-1:0] first_i,
    input  logic [NDS_W-1:0] nwords_i,
    input  logic [AW-1:0]    base_i,
    input  logic             rd_valid_i,
    input  logic             misalign_i,
    output logic             rd_req_o,
    output logic [AW-1:0]    rd_addr_o,
    output logic             fetch_we_o,
    output logic [SEL_W-1:0] fetch_sel_o,
    output logic             init_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             cfg_err_o,
    output logic             align_err_o
);
    seq_state_e       state;
    logic [SEL_W-1:0] slot_q;
    logic [NDS_W-1:0] left_q;
    logic [AW-1:0]    addr_q;

    // Advance the sequence and keep the error and done flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            slot_q      <= '0;
            left_q      <= '0;
            addr_q      <= '0;
            done_o      <= 1'b0;
            cfg_err_o   <= 1'b0;
            align_err_o <= 1'b0;
        end else begin
            done_o <= (state == ST_FIN);
            case (state)
                ST_IDLE: if (start_i) begin
                    if (!legal_i) begin
                        cfg_err_o <= 1'b1;
                    end else begin
                        cfg_err_o   <= 1'b0;
                        align_err_o <= 1'b0;
                        slot_q      <= first_i;
                        left_q      <= nwords_i;
                        addr_q      <= base_i;
                        state       <= no_fetch_i ? ST_FIN : ST_REQ;
                    end
                end
                ST_REQ:  state <= ST_WAIT;
                ST_WAIT: if (rd_valid_i) begin
                    if (left_q == NDS_W'(1)) begin
                        state <= ST_FIN;
                    end else begin
                        slot_q <= slot_q + SEL_W'(1);
                        left_q <= left_q - NDS_W'(1);
                        addr_q <= addr_q + AW'(2);
                        state  <= ST_REQ;
                    end
                end
                ST_FIN: begin
                    align_err_o <= misalign_i;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rd_req_o    = (state == ST_REQ);
    assign rd_addr_o   = addr_q;
    assign fetch_we_o  = (state == ST_WAIT) && rd_valid_i;
    assign fetch_sel_o = slot_q;
    assign init_o      = (state == ST_FIN);
    assign busy_o      = (state != ST_IDLE);

    p_single_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> $stable(rd_addr_o));
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_reject_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_i && !legal_i) |=> (!busy_o && !rd_req_o && cfg_err_o));
endmodule

// File: rtl/desc_fetch_seq.sv
// Module: top of the descriptor fetch sequencer. It joins the mode decoder,
// the slot registers and the fetch controller. It muxes the single register
// write path between the idle-time preload port and returned descriptor
// words. Assumes DW >= 10 so the config fields fit.
module desc_fetch_seq
    import dfs_pkg::*;
#(
    parameter int DW = 16,
    localparam int AW = 2 * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             start_i,
    output logic             rd_req_o,
    output logic [AW-1:0]    rd_addr_o,
    input  logic             rd_valid_i,
    input  logic [DW-1:0]    rd_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             cfg_err_o,
    output logic             align_err_o,
    output logic [DW-1:0]    cfg_o,
    output logic [AW-1:0]    next_ptr_o,
    output logic [AW-1:0]    start_addr_o,
    output logic [DW-1:0]    xcnt_o,
    output logic [DW-1:0]    xmod_o,
    output logic [DW-1:0]    ycnt_o,
    output logic [DW-1:0]    ymod_o,
    output logic [AW-1:0]    cur_desc_o,
    output logic [AW-1:0]    cur_addr_o,
    output logic [DW-1:0]    cur_x_o,
    output logic [DW-1:0]    cur_y_o
);
    logic [NUM_SLOTS-1:0][DW-1:0] slot;
    logic             legal, no_fetch, from_cur, misalign, init;
    logic             fetch_we, reg_we;
    logic [SEL_W-1:0] first, fetch_sel, reg_sel;
    logic [NDS_W-1:0] nwords;
    logic [DW-1:0]    reg_wdata;
    logic [AW-1:0]    base;

    assign cfg_o        = slot[SL_CFG];
    assign next_ptr_o   = {slot[SL_NXT_HI], slot[SL_NXT_LO]};
    assign start_addr_o = {slot[SL_STA_HI], slot[SL_STA_LO]};
    assign xcnt_o       = slot[SL_XCNT];
    assign xmod_o       = slot[SL_XMOD];
    assign ycnt_o       = slot[SL_YCNT];
    assign ymod_o       = slot[SL_YMOD];

    assign base      = from_cur ? cur_desc_o : next_ptr_o;
    assign misalign  = misaligned(slot[SL_CFG][WSZ_LSB +: WSZ_W], slot[SL_STA_LO][1:0]);
    assign reg_we    = fetch_we | (wr_en_i & ~busy_o);
    assign reg_sel   = busy_o ? fetch_sel : wr_sel_i;
    assign reg_wdata = busy_o ? rd_data_i : wr_data_i;

    dfs_mode_dec #(.DW(DW)) u_dec (
        .cfg_i      (slot[SL_CFG]),
        .legal_o    (legal),
        .no_fetch_o (no_fetch),
        .from_cur_o (from_cur),
        .first_o    (first),
        .nwords_o   (nwords)
    );

    dfs_slot_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we),
        .sel_i      (reg_sel),
        .wdata_i    (reg_wdata),
        .init_i     (init),
        .slot_o     (slot),
        .cur_ptr_o  (cur_desc_o),
        .cur_addr_o (cur_addr_o),
        .cur_x_o    (cur_x_o),
        .cur_y_o    (cur_y_o)
    );

    dfs_fetch_ctl #(.AW(AW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .legal_i     (legal),
        .no_fetch_i  (no_fetch),
        .first_i     (first),
        .nwords_i    (nwords),
        .base_i      (base),
        .rd_valid_i  (rd_valid_i),
        .misalign_i  (misalign),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .fetch_we_o  (fetch_we),
        .fetch_sel_o (fetch_sel),
        .init_o      (init),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .cfg_err_o   (cfg_err_o),
        .align_err_o (align_err_o)
    );

    p_busy_write_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rd_valid_i) |=> $stable(slot));
endmodule

// File: tb/sim_desc_fetch_seq.sv
// Scoreboard bench: the driver predicts each run and queues the expected
// read addresses and final register state. The bus/monitor process serves
// reads, pops addresses, and compares results on each done pulse.
module sim_desc_fetch_seq;
    localparam int DW = 16;
    localparam int AW = 32;

    typedef struct {
        logic [31:0] cdp;
        logic [31:0] ca;
        logic [31:0] nxt;
        logic [15:0] cx;
        logic [15:0] cy;
        logic [15:0] cfg;
        logic [15:0] xmod;
        logic [15:0] ymod;
        logic        aerr;
        int          nw;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_sel = '0;
    logic [15:0]   wr_data = '0;
    logic          start = 1'b0;
    logic          rd_req;
    logic [31:0]   rd_addr;
    logic          rd_valid = 1'b0;
    logic [15:0]   rd_data = '0;
    logic          busy, done, cfg_err, align_err;
    logic [15:0]   cfg_w, xcnt_w, xmod_w, ycnt_w, ymod_w, cur_x, cur_y;
    logic [31:0]   next_ptr, start_addr, cur_desc, cur_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_valid_cyc = 0;
    int reads = 0;
    int lat = 0;
    logic [15:0] mem [0:127];
    logic [15:0] m [0:10];
    logic [31:0] addr_q [$];
    exp_t        exp_q [$];

    desc_fetch_seq #(.DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .start_i(start),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr),
        .rd_valid_i(rd_valid), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .cfg_err_o(cfg_err), .align_err_o(align_err),
        .cfg_o(cfg_w), .next_ptr_o(next_ptr), .start_addr_o(start_addr),
        .xcnt_o(xcnt_w), .xmod_o(xmod_w), .ycnt_o(ycnt_w), .ymod_o(ymod_w),
        .cur_desc_o(cur_desc), .cur_addr_o(cur_addr), .cur_x_o(cur_x), .cur_y_o(cur_y)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog run did not finish actual=%0d expected=0", 100000);
        summary();
    end

    // Bus model and monitor: serve reads, check addresses, compare on done.
    initial begin
        logic        pend = 1'b0;
        logic [31:0] paddr = '0;
        int          wn = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rd_valid = 1'b0;
            if (rd_req) begin
                pend  = 1'b1;
                paddr = rd_addr;
                wn    = lat;
                reads++;
                if (addr_q.size() == 0) check_eq("R12 unexpected read", paddr, 32'hFFFF_FFFF);
                else check_eq("R5 read address", paddr, addr_q.pop_front());
            end else if (pend) begin
                if (wn == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = mem[paddr[7:1]];
                    pend     = 1'b0;
                    last_valid_cyc = cyc;
                end else begin
                    wn--;
                end
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check_eq("R11 unexpected done", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check_eq({e.tag, " R8 cur desc"}, cur_desc, e.cdp);
                    check_eq({e.tag, " R8 cur addr"}, cur_addr, e.ca);
                    check_eq({e.tag, " next ptr"}, next_ptr, e.nxt);
                    check_eq({e.tag, " R9 cur x"}, {16'h0, cur_x}, {16'h0, e.cx});
                    check_eq({e.tag, " R9 cur y"}, {16'h0, cur_y}, {16'h0, e.cy});
                    check_eq({e.tag, " config"}, {16'h0, cfg_w}, {16'h0, e.cfg});
                    check_eq({e.tag, " x stride"}, {16'h0, xmod_w}, {16'h0, e.xmod});
                    check_eq({e.tag, " y stride"}, {16'h0, ymod_w}, {16'h0, e.ymod});
                    check_eq({e.tag, " R10 align err"}, {31'h0, align_err}, {31'h0, e.aerr});
                    check_eq({e.tag, " R11 idle at done"}, {31'h0, busy}, 32'h0);
                    if (e.nw > 0)
                        check_eq({e.tag, " R11 done latency"}, cyc - last_valid_cyc, 32'd2);
                end
            end
        end
    end

    task automatic wr_reg(input logic [3:0] sel, input logic [15:0] data, input bit track);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        if (track) m[sel] = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Predict the outcome from the requirements, queue it, then pulse start.
    task automatic launch(input string tag, output bit legal);
        logic [15:0] c;
        logic [2:0]  flow;
        logic [3:0]  nds;
        int          first, maxn;
        bit          from_cur, nofetch;
        logic [31:0] base, a;
        exp_t        e;
        c = m[4]; flow = c[2:0]; nds = c[7:4];
        first = 0; maxn = 0; from_cur = 0; nofetch = 0; legal = 0;
        case (flow)
            3'd0, 3'd1: begin nofetch = 1; legal = (nds == 0); end
            3'd2: begin first = 2; maxn = 7; from_cur = 1; end
            3'd3: begin first = 1; maxn = 8; end
            3'd4: begin first = 0; maxn = 9; end
            default: legal = 0;
        endcase
        if (!nofetch && maxn > 0) legal = (nds >= 1) && (int'(nds) <= maxn);
        if (legal) begin
            base = from_cur ? {m[10], m[9]} : {m[1], m[0]};
            if (!nofetch) begin
                for (int k = 0; k < int'(nds); k++) begin
                    a = base + 32'(2 * k);
                    addr_q.push_back(a);
                    m[first + k] = mem[a[7:1]];
                end
            end
            m[9] = m[0]; m[10] = m[1];
            e.cdp  = {m[1], m[0]};
            e.nxt  = {m[1], m[0]};
            e.ca   = {m[3], m[2]};
            e.cx   = (m[5] == 0) ? 16'hFFFF : m[5];
            e.cy   = (m[7] == 0) ? 16'hFFFF : m[7];
            e.cfg  = m[4];
            e.xmod = m[6];
            e.ymod = m[8];
            case (m[4][9:8])
                2'd0:    e.aerr = 1'b0;
                2'd1:    e.aerr = m[2][0];
                default: e.aerr = (m[2][1:0] != 2'b00);
            endcase
            e.nw  = nofetch ? 0 : int'(nds);
            e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic finish_run(input string tag, input bit legal, input int reads_before);
        if (legal) begin
            for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
            @(negedge clk);
            check_eq({tag, " R3 no cfg error"}, {31'h0, cfg_err}, 32'h0);
        end else begin
            repeat (4) @(negedge clk);
            check_eq({tag, " R3 cfg error"}, {31'h0, cfg_err}, 32'h1);
            check_eq({tag, " R3 stays idle"}, {31'h0, busy}, 32'h0);
            check_eq({tag, " R3 no reads"}, reads - reads_before, 32'd0);
        end
    endtask

    task automatic run(input string tag);
        bit lg;
        int rb;
        rb = reads;
        launch(tag, lg);
        finish_run(tag, lg, rb);
    endtask

    initial begin
        logic [31:0] ca_hold;
        bit          lg;
        int          rb;
        for (int i = 0; i < 128; i++) mem[i] = 16'(i * 16'h0101);
        for (int i = 0; i < 11; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 busy", {31'h0, busy}, 32'h0);
        check_eq("R1 done", {31'h0, done}, 32'h0);
        check_eq("R1 read req", {31'h0, rd_req}, 32'h0);
        check_eq("R1 errors", {30'h0, cfg_err, align_err}, 32'h0);
        check_eq("R1 cur addr", cur_addr, 32'h0);
        check_eq("R1 config", {16'h0, cfg_w}, 32'h0);

        // R2 preload write while idle
        wr_reg(4'd6, 16'h1234, 1);
        check_eq("R2 preload x stride", {16'h0, xmod_w}, 32'h1234);

        // R5 large list, 9 words, 2-byte elements
        mem[8] = 16'h0040; mem[9] = 16'h0000; mem[10] = 16'h0102; mem[11] = 16'h0000;
        mem[12] = 16'h0100; mem[13] = 16'h0005; mem[14] = 16'h0002; mem[15] = 16'h0000;
        mem[16] = 16'h0004;
        wr_reg(4'd0, 16'h0010, 1);
        wr_reg(4'd1, 16'h0000, 1);
        wr_reg(4'd4, 16'h0194, 1);
        run("R5 large");

        // R6 small list, 3 words, 4-byte elements, misaligned start (R10)
        lat = 1;
        mem[32] = 16'h0000; mem[33] = 16'h0206; mem[34] = 16'h0001;
        wr_reg(4'd4, 16'h0233, 1);
        run("R6 small R10");

        // R7 array, 7 words from current pointer, zero X count (R9)
        lat = 2;
        mem[48] = 16'h0300; mem[49] = 16'h0000; mem[50] = 16'h0200; mem[51] = 16'h0000;
        mem[52] = 16'h0004; mem[53] = 16'h0003; mem[54] = 16'h0008;
        wr_reg(4'd9, 16'h0060, 1);
        wr_reg(4'd10, 16'h0000, 1);
        wr_reg(4'd4, 16'h0272, 1);
        run("R7 array R9");

        // R4 stop mode, byte elements, odd start is fine
        lat = 0;
        wr_reg(4'd2, 16'h0005, 1);
        wr_reg(4'd3, 16'h0000, 1);
        wr_reg(4'd5, 16'h0007, 1);
        wr_reg(4'd7, 16'h0001, 1);
        wr_reg(4'd4, 16'h0000, 1);
        rb = reads;
        run("R4 stop");
        check_eq("R4 stop no reads", reads - rb, 32'd0);

        // R4 autobuffer with 2-byte elements and odd start (R10)
        wr_reg(4'd4, 16'h0101, 1);
        run("R4 auto R10");
        ca_hold = cur_addr;

        // R3 illegal combinations
        wr_reg(4'd4, 16'h0002, 1); run("R3 array size 0");
        wr_reg(4'd4, 16'h00A4, 1); run("R3 large size 10");
        wr_reg(4'd4, 16'h0093, 1); run("R3 small size 9");
        wr_reg(4'd4, 16'h0015, 1); run("R3 flow code 5");
        wr_reg(4'd4, 16'h0010, 1); run("R3 stop size 1");
        check_eq("R3 registers untouched", cur_addr, ca_hold);

        // R2/R12 write and start while busy are ignored
        lat = 3;
        mem[64] = 16'h0090; mem[65] = 16'h0000; mem[66] = 16'h0007; mem[67] = 16'h0000;
        wr_reg(4'd0, 16'h0080, 1);
        wr_reg(4'd1, 16'h0000, 1);
        wr_reg(4'd4, 16'h0044, 1);
        rb = reads;
        launch("R12 busy", lg);
        @(negedge clk);
        check_eq("R12 busy during fetch", {31'h0, busy}, 32'h1);
        wr_reg(4'd6, 16'hBEEF, 0);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        finish_run("R12 busy", lg, rb);
        check_eq("R2 busy write ignored", {16'h0, xmod_w}, {16'h0, m[6]});
        check_eq("R12 read count", reads - rb, 32'd4);
        check_eq("R12 no extra done", exp_q.size(), 32'd0);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule